// File: doc/BRIEF.md
# PRBS11 Byte-Wide Generator and Bit-Error Checker

This block is a link test aid with two independent halves. The generator half emits a pseudo-random binary sequence of period 2047, eight sequence bits per clock, so at 125 MHz it supplies a 1 Gbps test stream. The checker half takes an 8-bit received stream, finds the sequence phase by itself, confirms the lock, and then counts bit errors and compared bits at the full rate of eight bits per clock.

The sequence obeys b[n] = b[n-11] XOR b[n-9], the recurrence of x^11 + x^9 + 1. On both sides, bit 7 of a byte is the earliest bit in time and bit 0 the latest. The checker is a three-state machine. HUNT takes two received bytes to fill an 11-bit history, which leaves on the fill_done transition. VERIFY loads that history into the local LFSR on every byte. A byte that is free of errors advances a run count. A mismatch, or an all-zero window, takes the reload transition and restarts the run. After 64 clean bytes in a row the confirm transition enters LOCKED. In LOCKED the local LFSR runs freely. Each byte's error count is the population count of received XOR expected, and it is added to a saturating counter. The drop transition returns to VERIFY when more than 16 errors build up inside one 128-byte window. The counters can be cleared at any time without disturbing the lock.

Top module: `prbs_ber_top`

## Requirements
- R1: After reset the generator window holds SEED, with SEED bit 10 as the earliest bit. In each clock where gen_en is high, the next eight sequence bits appear on gen_data one cycle later, with gen_vld high. Bit 7 is the earliest bit.
- R2: In a clock where gen_en is low, gen_vld goes low in the next cycle and the sequence does not advance. The next enabled byte continues where the stream stopped.
- R3: From reset, a clean stream at any bit phase raises sync exactly at the 66th valid byte: two fill bytes, then 64 clean bytes.
- R4: In VERIFY, a byte with any bit error restarts the 64-byte run from zero.
- R5: An all-zero input stream never raises sync.
- R6: While sync is high, each valid byte adds 8 to bit_count and adds the number of differing bits to err_count. While sync is low, neither counter changes.
- R7: While locked, the checker drops sync on the byte that takes the errors of the current 128-byte window above 16. That byte is still counted. Windows start at the lock point and restart every 128 bytes. Afterwards the checker relocks on clean data.
- R8: Both counters saturate at all ones and never wrap.
- R9: cnt_clr zeroes both counters and leaves sync unchanged. When cnt_clr and a scored byte arrive in the same cycle, the counters hold only that byte's contribution.
- R10: Cycles with rx_vld low change neither the counters nor the lock state, whatever is on rx_data.
- R11: Reset clears sync, both counters and gen_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Generator advance request |
| gen_data | output | 8 | Generated byte, bit 7 earliest |
| gen_vld | output | 1 | gen_data holds a new byte |
| rx_data | input | 8 | Received byte, bit 7 earliest |
| rx_vld | input | 1 | rx_data is valid this cycle |
| cnt_clr | input | 1 | Zero both counters |
| sync | output | 1 | Checker is locked |
| err_count | output | CNT_W | Saturating bit-error count |
| bit_count | output | CNT_W | Saturating compared-bit count |

## Verification
The counter clear and the scoring of a locked byte can happen in the same clock. The bench provokes this by pulsing cnt_clr together with a byte that carries three flipped bits. It expects err_count to read 3 and bit_count to read 8, and it expects sync to stay high. A second collision is the window boundary. Here the byte that completes a window and the restart of the next window fall together. The bench places 16 errors so that the last of them lands on the final byte of a window and more errors land on the next byte. It then judges that sync holds and that every error was counted.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;
    localparam int SEQ_W   = 11;
    localparam int TAP_IX  = 8;
    localparam int LANE_W  = 8;
    localparam int POP_W   = $clog2(LANE_W + 1);

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_VERIFY,
        ST_LOCKED
    } lock_state_e;

    typedef struct packed {
        logic [SEQ_W-1:0]  win;
        logic [LANE_W-1:0] bits;
    } adv_t;

    // Eight serial steps of b[n] = b[n-11] ^ b[n-9], unrolled.
    function automatic adv_t lfsr_adv(input logic [SEQ_W-1:0] w);
        adv_t r;
        logic nb;
        r.win  = w;
        r.bits = '0;
        for (int i = 0; i < LANE_W; i++) begin
            nb = r.win[SEQ_W-1] ^ r.win[TAP_IX];
            r.bits[LANE_W-1-i] = nb;
            r.win = {r.win[SEQ_W-2:0], nb};
        end
        return r;
    endfunction

    function automatic logic [POP_W-1:0] pop_lane(input logic [LANE_W-1:0] v);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANE_W; i++) begin
            n = n + POP_W'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/prbs_gen_core.sv
module prbs_gen_core
    import prbs_ber_pkg::*;
#(
    parameter logic [SEQ_W-1:0] SEED = 11'h5A3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [LANE_W-1:0] data,
    output logic              vld
);
    logic [SEQ_W-1:0] win_q;
    adv_t             step;

    always_comb begin
        step = lfsr_adv(win_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= SEED;
            data  <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= en;
            if (en) begin
                win_q <= step.win;
                data  <= step.bits;
            end
        end
    end
endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
    import prbs_ber_pkg::*;
#(
    parameter int LOCK_RUN = 64,
    parameter int WIN_LEN  = 128,
    parameter int DROP_LIM = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] rx_data,
    input  logic              rx_vld,
    output logic              locked,
    output logic              score_en,
    output logic [POP_W-1:0]  byte_errs
);
    localparam int GOOD_W = $clog2(LOCK_RUN);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int ERR_W  = $clog2(DROP_LIM + LANE_W + 1);

    lock_state_e       st_q, st_d;
    logic [SEQ_W-1:0]  win_q, win_d;
    logic [SEQ_W-1:0]  hist_q, hist_d;
    logic              fill_q, fill_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [WIN_W-1:0]  wcnt_q, wcnt_d;
    logic [ERR_W-1:0]  werr_q, werr_d;

    adv_t              pred;
    logic [SEQ_W-1:0]  hist_nx;
    logic [ERR_W-1:0]  tot;
    logic              clean;

    // Output and datapath decode
    always_comb begin
        pred      = lfsr_adv(win_q);
        hist_nx   = {hist_q[SEQ_W-LANE_W-1:0], rx_data};
        byte_errs = pop_lane(rx_data ^ pred.bits);
        tot       = werr_q + ERR_W'(byte_errs);
        clean     = (byte_errs == '0) && (hist_nx != '0);
        locked    = (st_q == ST_LOCKED);
        score_en  = locked && rx_vld;
    end

    // Next-state decode
    always_comb begin
        st_d   = st_q;
        win_d  = win_q;
        hist_d = hist_q;
        fill_d = fill_q;
        good_d = good_q;
        wcnt_d = wcnt_q;
        werr_d = werr_q;
        if (rx_vld) begin
            hist_d = hist_nx;
            unique case (st_q)
                ST_HUNT: begin
                    win_d  = hist_nx;
                    fill_d = 1'b1;
                    if (fill_q) begin
                        st_d   = ST_VERIFY;       // fill_done
                        good_d = '0;
                    end
                end
                ST_VERIFY: begin
                    win_d = hist_nx;
                    if (!clean) begin
                        good_d = '0;              // reload
                    end else if (good_q == GOOD_W'(LOCK_RUN - 1)) begin
                        st_d   = ST_LOCKED;       // confirm
                        wcnt_d = '0;
                        werr_d = '0;
                    end else begin
                        good_d = good_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    win_d = pred.win;
                    if (tot > ERR_W'(DROP_LIM)) begin
                        st_d   = ST_VERIFY;       // drop
                        win_d  = hist_nx;
                        good_d = '0;
                    end else if (wcnt_q == WIN_W'(WIN_LEN - 1)) begin
                        wcnt_d = '0;
                        werr_d = '0;
                    end else begin
                        wcnt_d = wcnt_q + 1'b1;
                        werr_d = tot;
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            win_q  <= '0;
            hist_q <= '0;
            fill_q <= 1'b0;
            good_q <= '0;
            wcnt_q <= '0;
            werr_q <= '0;
        end else begin
            st_q   <= st_d;
            win_q  <= win_d;
            hist_q <= hist_d;
            fill_q <= fill_d;
            good_q <= good_d;
            wcnt_q <= wcnt_d;
            werr_q <= werr_d;
        end
    end
endmodule

// File: rtl/ber_tally.sv
module ber_tally #(
    parameter int W     = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] add_val,
    output logic [W-1:0]     count
);
    logic [W:0]   sum;
    logic [W-1:0] contrib;

    always_comb begin
        contrib = add_en ? W'(add_val) : '0;
        sum     = {1'b0, count} + {1'b0, contrib};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= contrib;
        end else if (add_en) begin
            count <= sum[W] ? '1 : sum[W-1:0];
        end
    end
endmodule

// File: rtl/prbs_ber_top.sv
module prbs_ber_top
    import prbs_ber_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter logic [SEQ_W-1:0] SEED     = 11'h5A3,
    parameter int               LOCK_RUN = 64,
    parameter int               WIN_LEN  = 128,
    parameter int               DROP_LIM = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    output logic [7:0]       gen_data,
    output logic             gen_vld,
    input  logic [7:0]       rx_data,
    input  logic             rx_vld,
    input  logic             cnt_clr,
    output logic             sync,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] bit_count
);
    localparam logic [POP_W-1:0] LANE_BITS = POP_W'(LANE_W);

    logic             score_en;
    logic [POP_W-1:0] byte_errs;

    prbs_gen_core #(.SEED(SEED)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .en   (gen_en),
        .data (gen_data),
        .vld  (gen_vld)
    );

    prbs_lock_fsm #(
        .LOCK_RUN (LOCK_RUN),
        .WIN_LEN  (WIN_LEN),
        .DROP_LIM (DROP_LIM)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rx_data   (rx_data),
        .rx_vld    (rx_vld),
        .locked    (sync),
        .score_en  (score_en),
        .byte_errs (byte_errs)
    );

    ber_tally #(.W(CNT_W), .INC_W(POP_W)) u_err_tally (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .add_en  (score_en),
        .add_val (byte_errs),
        .count   (err_count)
    );

    ber_tally #(.W(CNT_W), .INC_W(POP_W)) u_bit_tally (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .add_en  (score_en),
        .add_val (LANE_BITS),
        .count   (bit_count)
    );
endmodule

// File: rtl/prbs_ber_props.sv
module prbs_ber_props #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             gen_en,
    input logic             gen_vld,
    input logic             rx_vld,
    input logic             cnt_clr,
    input logic             sync,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count
);
    assert_gen_follow_R1: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> gen_vld);

    assert_gen_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !gen_vld);

    assert_lock_on_data_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sync) |-> $past(rx_vld));

    assert_no_score_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        (!sync && !cnt_clr) |=> ($stable(bit_count) && $stable(err_count)));

    assert_err_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (err_count >= $past(err_count)));

    assert_bits_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (bit_count >= $past(bit_count)));

    assert_clear_level_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (bit_count <= CNT_W'(8) && err_count <= CNT_W'(8)));

    assert_clear_keeps_sync_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_clr && !rx_vld) |=> $stable(sync));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rx_vld && !cnt_clr) |=> ($stable(bit_count) && $stable(err_count) && $stable(sync)));
endmodule

bind prbs_ber_top prbs_ber_props #(.CNT_W(CNT_W)) u_props (
    .clk       (clk),
    .rst       (rst),
    .gen_en    (gen_en),
    .gen_vld   (gen_vld),
    .rx_vld    (rx_vld),
    .cnt_clr   (cnt_clr),
    .sync      (sync),
    .err_count (err_count),
    .bit_count (bit_count)
);

// File: tb/sim_prbs_ber_top.sv
module sim_prbs_ber_top;
    localparam int         CW   = 12;
    localparam logic [10:0] SEED = 11'h5A3;
    localparam int         PER  = 2047;

    // Table: start phase, bytes sent, expected sync, expected bit_count
    localparam int NV = 5;
    localparam int V_PH [NV] = '{0, 0, 3, 777, 2040};
    localparam int V_N  [NV] = '{65, 66, 67, 90, 200};
    localparam int V_SY [NV] = '{0, 1, 1, 1, 1};
    localparam int V_BT [NV] = '{0, 0, 8, 192, 1072};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gen_en = 1'b0;
    logic [7:0]    gen_data;
    logic          gen_vld;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_vld = 1'b0;
    logic          cnt_clr = 1'b0;
    logic          sync;
    logic [CW-1:0] err_count;
    logic [CW-1:0] bit_count;

    logic seq [PER];
    int   pos;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    prbs_ber_top #(.CNT_W(CW), .SEED(SEED)) u0 (
        .clk       (clk),
        .rst       (rst),
        .gen_en    (gen_en),
        .gen_data  (gen_data),
        .gen_vld   (gen_vld),
        .rx_data   (rx_data),
        .rx_vld    (rx_vld),
        .cnt_clr   (cnt_clr),
        .sync      (sync),
        .err_count (err_count),
        .bit_count (bit_count)
    );

    function automatic logic [7:0] byte_at(input int p);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7-j] = seq[(p + j) % PER];
        return b;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic send_raw(input logic [7:0] d, input logic c);
        rx_data = d;
        rx_vld  = 1'b1;
        cnt_clr = c;
        @(posedge clk);
        #1;
        rx_vld  = 1'b0;
        cnt_clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] mask, input logic c);
        send_raw(byte_at(pos) ^ mask, c);
        pos += 8;
    endtask

    task automatic send_clean(input int n);
        for (int i = 0; i < n; i++) send(8'h00, 1'b0);
    endtask

    task automatic lock_up();
        do_reset();
        pos = 0;
        send_clean(66);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) seq[i] = SEED[10-i];
        for (int i = 11; i < PER; i++) seq[i] = seq[i-11] ^ seq[i-9];

        // R11: reset state
        do_reset();
        check("R11", "sync", sync, 0);
        check("R11", "err_count", err_count, 0);
        check("R11", "bit_count", bit_count, 0);
        check("R11", "gen_vld", gen_vld, 0);

        // R1 / R2: generator stream, pause, resume
        gen_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #1;
            check("R1", "gen_vld", gen_vld, 1);
            check("R1", "gen_data", gen_data, byte_at(11 + 8 * i));
        end
        gen_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R2", "gen_vld paused", gen_vld, 0);
        gen_en = 1'b1;
        @(posedge clk);
        #1;
        gen_en = 1'b0;
        check("R2", "gen_data resumed", gen_data, byte_at(51));

        // R3: lock time at several phases (table)
        for (int v = 0; v < NV; v++) begin
            do_reset();
            pos = V_PH[v];
            send_clean(V_N[v]);
            check("R3", "sync at table row", sync, V_SY[v]);
            check("R3", "bit_count at table row", bit_count, V_BT[v]);
        end

        // R4: a mismatch in VERIFY restarts the run
        do_reset();
        pos = 0;
        send_clean(39);
        send(8'h80, 1'b0);
        send_clean(64);
        check("R4", "sync one byte short", sync, 0);
        send_clean(1);
        check("R4", "sync after restarted run", sync, 1);

        // R5: all-zero stream
        do_reset();
        for (int i = 0; i < 100; i++) send_raw(8'h00, 1'b0);
        check("R5", "sync on zeros", sync, 0);

        // R6 / R7: scoring and drop
        lock_up();
        send_clean(10);
        check("R6", "bit_count clean", bit_count, 80);
        check("R6", "err_count clean", err_count, 0);
        send(8'h81, 1'b0);
        check("R6", "err_count two flips", err_count, 2);
        send(8'hFF, 1'b0);
        send(8'h07, 1'b0);
        check("R7", "sync at 13 window errors", sync, 1);
        send(8'h0F, 1'b0);
        check("R7", "sync after 17 window errors", sync, 0);
        check("R7", "err_count incl drop byte", err_count, 17);
        check("R7", "bit_count incl drop byte", bit_count, 112);
        send_clean(2);
        check("R6", "no scoring unlocked", bit_count, 112);
        send_clean(70);
        check("R7", "relock", sync, 1);

        // R7: window boundary
        lock_up();
        send_clean(120);
        send(8'hFF, 1'b0);
        send_clean(6);
        send(8'hFF, 1'b0);
        send(8'hFF, 1'b0);
        send(8'hFF, 1'b0);
        check("R7", "sync across window edge", sync, 1);
        check("R7", "err_count across edge", err_count, 32);
        check("R7", "bit_count across edge", bit_count, 1040);
        send(8'h01, 1'b0);
        check("R7", "drop in second window", sync, 0);
        check("R7", "err_count second drop", err_count, 33);

        // R9: clear together with a scored byte, then clear alone
        lock_up();
        send_clean(5);
        send(8'h07, 1'b1);
        check("R9", "err_count clear+byte", err_count, 3);
        check("R9", "bit_count clear+byte", bit_count, 8);
        check("R9", "sync kept", sync, 1);
        cnt_clr = 1'b1;
        @(posedge clk);
        #1;
        cnt_clr = 1'b0;
        check("R9", "err_count clear only", err_count, 0);
        check("R9", "bit_count clear only", bit_count, 0);
        check("R9", "sync after clear only", sync, 1);

        // R10: invalid cycles with noise on rx_data
        rx_data = 8'hA5;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "bit_count idle", bit_count, 0);
        check("R10", "sync idle", sync, 1);
        send_clean(1);
        check("R10", "err_count after idle", err_count, 0);
        check("R10", "bit_count after idle", bit_count, 8);

        // R8: saturation
        lock_up();
        send_clean(520);
        check("R8", "bit_count saturated", bit_count, 4095);
        check("R8", "err_count clean", err_count, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule